// File: doc/BRIEF.md
# Host Command Port Register Interface

This block is the host-facing register file of a byte-wide parallel slave port on a processor. An external host reaches it with a strobe, an optional acknowledge, a read/write select and a 3-bit register address. Three locations matter. The control register enables the two host request conditions, carries two host flags and a two-bit transfer mode toward the core, and holds a self-clearing initialise bit. The command register lets the host choose an interrupt vector and raise it as a command toward the core. The data location moves one byte in each direction between host and core.

A host command stays pending until the core reports that it has taken it. The core sees the vector address as twice the programmed vector. While a command is pending, the vector is frozen so that the core always services the value the host armed. In polling mode the host watches a single request output. This output reflects an empty host-to-core byte register and/or a full core-to-host byte register, gated by the two enables.

Top module: `host_cmd_port`

## Requirements
- R1: After reset the control register reads 0x00, the command register reads 0x17 (vector 0x17, command clear), the vector address is 0x002E, both byte registers are empty and `host_req` is low.
- R2: A host access takes effect only while `host_strb` and `host_ack` are both high (acknowledge mode on by default). It takes effect exactly once per strobe assertion, at the first rising edge of the qualified strobe. A strobe without acknowledge changes nothing.
- R3: The control register is at address 0. Bit 0 enables the request for a full core-to-host byte, and bit 1 enables the request for an empty host-to-core byte. Bit 2 always reads 0. Bits 3 and 4 drive `core_host_flags[0]` and `[1]`, and bits 6:5 drive `core_dma_mode`.
- R4: Writing 1 to control bit 7 empties both byte registers on the next edge. The bit is self-clearing and reads 0 one idle cycle later.
- R5: The command register is at address 1. Bit 7 is the command bit and bits 4:0 are the vector. Bits 6:5 always read 0.
- R6: `core_cmd_vaddr` always equals twice the stored vector, zero-extended.
- R7: A host write with bit 7 set makes `core_cmd_pending` high. It stays high, and bit 7 reads 1, until a `core_cmd_taken` pulse clears it. A host write of 0 does not clear it.
- R8: While a command is pending, host writes to the command register leave the vector unchanged.
- R9: `host_req` = (bit 1 AND host-to-core empty) OR (bit 0 AND core-to-host full). With both enables 0 it stays low.
- R10: Address 4 is the data byte. A host write loads `core_h2c_data` and sets `core_h2c_full`, which `core_h2c_rd` clears. A `core_c2h_wr` sets `core_c2h_full`, and a host read returns that byte and clears the flag.
- R11: Addresses 2, 3, 5, 6 and 7 read 0x00 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_strb | input | 1 | Host access strobe, active high |
| host_ack | input | 1 | Host acknowledge, qualifies the strobe when acknowledge mode is on |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the addressed register |
| host_req | output | 1 | Polling request to the host |
| core_cmd_pending | output | 1 | Host command waiting for the core |
| core_cmd_vaddr | output | VADDR_W | Interrupt vector address (twice the vector) |
| core_cmd_taken | input | 1 | Core pulse: command serviced |
| core_host_flags | output | 2 | Host flag bits |
| core_dma_mode | output | 2 | Transfer mode bits (00 = polling/interrupt) |
| core_rx_req_en | output | 1 | Core-to-host request enable |
| core_tx_req_en | output | 1 | Host-to-core request enable |
| core_h2c_data | output | 8 | Byte written by the host |
| core_h2c_full | output | 1 | Host-to-core byte waiting |
| core_h2c_rd | input | 1 | Core pulse: host-to-core byte consumed |
| core_c2h_data | input | 8 | Byte for the host |
| core_c2h_wr | input | 1 | Core pulse: load core-to-host byte |
| core_c2h_full | output | 1 | Core-to-host byte waiting |

## Verification
The bench holds a strobe across several cycles while the core takes a command mid-hold. A design that acted on the level rather than the edge would re-arm the command. Host writes of 0 and of new vectors are issued while a command is pending; a design that let them through would drop the command early or move the vector under the core. The initialise bit is written while both byte registers are full. This catches a design that fails to empty them or leaves the bit stuck at 1. A strobe without acknowledge and accesses to unused addresses are also driven, because a sloppy decode would let them change registers.

// File: rtl/host_cmd_port_pkg.sv
// Shared types and address map for the host command port.
// Assumes an 8-bit host data bus and a 3-bit register address.
package host_cmd_port_pkg;

    localparam int unsigned HOST_AW = 3;
    localparam int unsigned HOST_DW = 8;

    localparam logic [HOST_AW-1:0] ADDR_CTRL = 3'd0;
    localparam logic [HOST_AW-1:0] ADDR_CMD  = 3'd1;
    localparam logic [HOST_AW-1:0] ADDR_DATA = 3'd4;

    // Control register layout, bit 7 down to bit 0.
    typedef struct packed {
        logic       init;
        logic [1:0] mode;
        logic       flag1;
        logic       flag0;
        logic       rsvd;
        logic       tx_en;
        logic       rx_en;
    } ctrl_reg_t;

endpackage

// File: rtl/hcp_host_access.sv
// Qualifies the host strobe and produces one-cycle access pulses.
// What: an access fires on the first cycle in which strobe (and ack, when
// acknowledge mode is on) is high; it does not repeat while held.
// Assumes host signals are synchronous to clk.
module hcp_host_access
    import host_cmd_port_pkg::*;
#(
    parameter bit USE_ACK = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strb,
    input  logic               ack,
    input  logic               rd,
    input  logic [HOST_AW-1:0] addr,
    output logic               wr_ctrl,
    output logic               wr_cmd,
    output logic               wr_data,
    output logic               rd_data
);

    logic qual;
    logic qual_q;
    logic fire;

    // Select whether the acknowledge input takes part in qualification.
    generate
        if (USE_ACK) begin : g_ack
            assign qual = strb & ack;
        end else begin : g_noack
            logic ack_unused;
            assign ack_unused = ack;
            assign qual = strb;
        end
    endgenerate

    // Remember the qualified strobe to find its leading edge.
    always_ff @(posedge clk) begin
        if (!rst_n) qual_q <= 1'b0;
        else        qual_q <= qual;
    end

    assign fire = qual & ~qual_q;

    // Decode the fired access into per-register strobes.
    always_comb begin
        wr_ctrl = fire & ~rd & (addr == ADDR_CTRL);
        wr_cmd  = fire & ~rd & (addr == ADDR_CMD);
        wr_data = fire & ~rd & (addr == ADDR_DATA);
        rd_data = fire &  rd & (addr == ADDR_DATA);
    end

    // R2
    one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/hcp_ctrl_reg.sv
// Control register: request enables, host flags, mode bits and the
// self-clearing initialise bit.
// Assumes write pulses are at least two cycles apart (edge-qualified).
module hcp_ctrl_reg
    import host_cmd_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  ctrl_reg_t wr_val,
    output ctrl_reg_t ctrl,
    output logic      init_clr
);

    ctrl_reg_t q;
    logic      init_q;

    // Store the writable fields; reserved and init bits never stick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            init_q <= 1'b0;
        end else begin
            init_q <= 1'b0;
            if (wr_en) begin
                q      <= wr_val;
                q.rsvd <= 1'b0;
                q.init <= 1'b0;
                init_q <= wr_val.init;
            end
        end
    end

    // Present the register with the one-cycle initialise flag folded in.
    always_comb begin
        ctrl      = q;
        ctrl.init = init_q;
    end

    assign init_clr = init_q;

    // R4
    init_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> !init_clr);

endmodule

// File: rtl/hcp_cmd_vector.sv
// Command register: host-chosen vector plus a pending command bit that
// only the core's taken pulse clears. The vector is frozen while pending.
// Assumes core_taken is a single-cycle pulse from the core.
module hcp_cmd_vector #(
    parameter int unsigned     VEC_W   = 5,
    parameter logic [VEC_W-1:0] VEC_RST = 5'h17,
    parameter int unsigned     VADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_cmd,
    input  logic [VEC_W-1:0]   wr_vec,
    input  logic               core_taken,
    output logic               pending,
    output logic [VEC_W-1:0]   vec,
    output logic [VADDR_W-1:0] vaddr
);

    localparam int unsigned PAD_W = VADDR_W - VEC_W - 1;

    // Accept host writes only when idle; core taken clears the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            vec     <= VEC_RST;
        end else begin
            if (core_taken) pending <= 1'b0;
            if (wr_en && !pending) begin
                vec     <= wr_vec;
                pending <= wr_cmd;
            end
        end
    end

    // Vector address is the vector shifted left by one.
    assign vaddr = {{PAD_W{1'b0}}, vec, 1'b0};

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !core_taken) |=> pending);

    // R8
    vec_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> $stable(vec));

endmodule

// File: rtl/hcp_data_regs.sv
// Single-byte registers in each direction and the polling request.
// Assumes core pulses and host access pulses are single-cycle.
module hcp_data_regs
    import host_cmd_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_DW-1:0] host_wdata,
    input  logic               core_h2c_rd,
    input  logic               core_c2h_wr,
    input  logic [HOST_DW-1:0] core_c2h_data,
    input  logic               init_clr,
    input  logic               tx_en,
    input  logic               rx_en,
    output logic [HOST_DW-1:0] h2c_byte,
    output logic               h2c_full,
    output logic [HOST_DW-1:0] c2h_byte,
    output logic               c2h_full,
    output logic               req
);

    // Host-to-core byte: host fills, core drains, initialise empties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h2c_byte <= '0;
            h2c_full <= 1'b0;
        end else if (init_clr) begin
            h2c_full <= 1'b0;
        end else if (host_wr) begin
            h2c_byte <= host_wdata;
            h2c_full <= 1'b1;
        end else if (core_h2c_rd) begin
            h2c_full <= 1'b0;
        end
    end

    // Core-to-host byte: core fills, host read drains, initialise empties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c2h_byte <= '0;
            c2h_full <= 1'b0;
        end else if (init_clr) begin
            c2h_full <= 1'b0;
        end else if (core_c2h_wr) begin
            c2h_byte <= core_c2h_data;
            c2h_full <= 1'b1;
        end else if (host_rd) begin
            c2h_full <= 1'b0;
        end
    end

    // Polling request combines the two enabled conditions.
    assign req = (tx_en & ~h2c_full) | (rx_en & c2h_full);

    // R4
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> (!h2c_full && !c2h_full));

    // R10
    c2h_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_c2h_wr && !init_clr) |=> c2h_full);

    // R10
    h2c_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !init_clr) |=> h2c_full);

endmodule

// File: rtl/host_cmd_port.sv
// Top of the host command port: host access decode, control register,
// command vector register and the two data byte registers.
// Assumes all inputs are synchronous to clk; reset is synchronous active low.
module host_cmd_port
    import host_cmd_port_pkg::*;
#(
    parameter bit               USE_ACK = 1'b1,
    parameter int unsigned      VEC_W   = 5,
    parameter logic [VEC_W-1:0] VEC_RST = 5'h17,
    parameter int unsigned      VADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_strb,
    input  logic               host_ack,
    input  logic               host_rd,
    input  logic [2:0]         host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    output logic               host_req,
    output logic               core_cmd_pending,
    output logic [VADDR_W-1:0] core_cmd_vaddr,
    input  logic               core_cmd_taken,
    output logic [1:0]         core_host_flags,
    output logic [1:0]         core_dma_mode,
    output logic               core_rx_req_en,
    output logic               core_tx_req_en,
    output logic [7:0]         core_h2c_data,
    output logic               core_h2c_full,
    input  logic               core_h2c_rd,
    input  logic [7:0]         core_c2h_data,
    input  logic               core_c2h_wr,
    output logic               core_c2h_full
);

    localparam int unsigned CMD_PAD = HOST_DW - 1 - VEC_W;

    logic                wr_ctrl;
    logic                wr_cmd;
    logic                wr_data;
    logic                rd_data;
    ctrl_reg_t           ctrl;
    ctrl_reg_t           ctrl_wval;
    logic                init_clr;
    logic [VEC_W-1:0]    vec;
    logic [HOST_DW-1:0]  c2h_byte;

    hcp_host_access #(.USE_ACK(USE_ACK)) u_access (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb    (host_strb),
        .ack     (host_ack),
        .rd      (host_rd),
        .addr    (host_addr),
        .wr_ctrl (wr_ctrl),
        .wr_cmd  (wr_cmd),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    assign ctrl_wval = ctrl_reg_t'(host_wdata);

    hcp_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ctrl),
        .wr_val   (ctrl_wval),
        .ctrl     (ctrl),
        .init_clr (init_clr)
    );

    hcp_cmd_vector #(
        .VEC_W   (VEC_W),
        .VEC_RST (VEC_RST),
        .VADDR_W (VADDR_W)
    ) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_cmd),
        .wr_cmd     (host_wdata[HOST_DW-1]),
        .wr_vec     (host_wdata[VEC_W-1:0]),
        .core_taken (core_cmd_taken),
        .pending    (core_cmd_pending),
        .vec        (vec),
        .vaddr      (core_cmd_vaddr)
    );

    hcp_data_regs u_data (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr       (wr_data),
        .host_rd       (rd_data),
        .host_wdata    (host_wdata),
        .core_h2c_rd   (core_h2c_rd),
        .core_c2h_wr   (core_c2h_wr),
        .core_c2h_data (core_c2h_data),
        .init_clr      (init_clr),
        .tx_en         (ctrl.tx_en),
        .rx_en         (ctrl.rx_en),
        .h2c_byte      (core_h2c_data),
        .h2c_full      (core_h2c_full),
        .c2h_byte      (c2h_byte),
        .c2h_full      (core_c2h_full),
        .req           (host_req)
    );

    // Core-facing view of the control register fields.
    assign core_host_flags = {ctrl.flag1, ctrl.flag0};
    assign core_dma_mode   = ctrl.mode;
    assign core_rx_req_en  = ctrl.rx_en;
    assign core_tx_req_en  = ctrl.tx_en;

    // Host read mux; unmapped addresses return zero.
    always_comb begin
        unique case (host_addr)
            ADDR_CTRL: host_rdata = ctrl;
            ADDR_CMD:  host_rdata = {core_cmd_pending, {CMD_PAD{1'b0}}, vec};
            ADDR_DATA: host_rdata = c2h_byte;
            default:   host_rdata = '0;
        endcase
    end

    // R5
    cmd_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == ADDR_CMD) |-> (host_rdata[6:5] == 2'b00));

    // R9
    req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_rx_req_en && !core_tx_req_en) |-> !host_req);

endmodule

// File: tb/host_cmd_port_test.sv
module host_cmd_port_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_strb = 1'b0;
    logic        host_ack = 1'b0;
    logic        host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_req;
    logic        core_cmd_pending;
    logic [15:0] core_cmd_vaddr;
    logic        core_cmd_taken = 1'b0;
    logic [1:0]  core_host_flags;
    logic [1:0]  core_dma_mode;
    logic        core_rx_req_en;
    logic        core_tx_req_en;
    logic [7:0]  core_h2c_data;
    logic        core_h2c_full;
    logic        core_h2c_rd = 1'b0;
    logic [7:0]  core_c2h_data = '0;
    logic        core_c2h_wr = 1'b0;
    logic        core_c2h_full;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [7:0] m_ctrl;
    logic [4:0] m_vec;
    logic       m_pend;
    logic [7:0] m_h2c;
    logic       m_h2c_full;
    logic [7:0] m_c2h;
    logic       m_c2h_full;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_cmd_port uut (
        .clk(clk), .rst_n(rst_n),
        .host_strb(host_strb), .host_ack(host_ack), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_req(host_req),
        .core_cmd_pending(core_cmd_pending), .core_cmd_vaddr(core_cmd_vaddr),
        .core_cmd_taken(core_cmd_taken),
        .core_host_flags(core_host_flags), .core_dma_mode(core_dma_mode),
        .core_rx_req_en(core_rx_req_en), .core_tx_req_en(core_tx_req_en),
        .core_h2c_data(core_h2c_data), .core_h2c_full(core_h2c_full),
        .core_h2c_rd(core_h2c_rd),
        .core_c2h_data(core_c2h_data), .core_c2h_wr(core_c2h_wr),
        .core_c2h_full(core_c2h_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_req();
        return (m_ctrl[1] & ~m_h2c_full) | (m_ctrl[0] & m_c2h_full);
    endfunction

    function automatic logic [7:0] exp_cmd_read();
        return {m_pend, 2'b00, m_vec};
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_ctrl;
            3'd1:    return exp_cmd_read();
            3'd4:    return m_c2h;
            default: return 8'h00;
        endcase
    endfunction

    // Compare every core-side output and the request against the model.
    task automatic check_core();
        chk("R7 pending", core_cmd_pending, m_pend);
        chk("R6 vaddr", core_cmd_vaddr, {10'd0, m_vec, 1'b0});
        chk("R3 flags", core_host_flags, m_ctrl[4:3]);
        chk("R3 mode", core_dma_mode, m_ctrl[6:5]);
        chk("R3 enables", {core_tx_req_en, core_rx_req_en}, m_ctrl[1:0]);
        chk("R10 h2c_full", core_h2c_full, m_h2c_full);
        chk("R10 c2h_full", core_c2h_full, m_c2h_full);
        if (m_h2c_full) chk("R10 h2c_data", core_h2c_data, m_h2c);
        chk("R9 host_req", host_req, exp_req());
    endtask

    // One host access: strobe for one cycle, then one idle cycle.
    task automatic host_op(input bit rd, input logic [2:0] a, input logic [7:0] d,
                           output logic [7:0] q);
        @(negedge clk);
        host_strb = 1'b1; host_ack = 1'b1; host_rd = rd;
        host_addr = a; host_wdata = d;
        #1 q = host_rdata;
        @(negedge clk);
        host_strb = 1'b0; host_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: begin
                m_ctrl = d & 8'h7B;
                if (d[7]) begin m_h2c_full = 1'b0; m_c2h_full = 1'b0; end
            end
            3'd1: if (!m_pend) begin m_vec = d[4:0]; m_pend = d[7]; end
            3'd4: begin m_h2c = d; m_h2c_full = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] q;
        host_op(1'b0, a, d, q);
        model_write(a, d);
        check_core();
    endtask

    task automatic do_read(input string req, input logic [2:0] a);
        logic [7:0] q;
        host_op(1'b1, a, 8'h00, q);
        chk(req, q, exp_read(a));
        if (a == 3'd4) m_c2h_full = 1'b0;
        check_core();
    endtask

    task automatic core_pulse(input int which, input logic [7:0] d);
        @(negedge clk);
        case (which)
            0: core_cmd_taken = 1'b1;
            1: core_h2c_rd = 1'b1;
            default: begin core_c2h_wr = 1'b1; core_c2h_data = d; end
        endcase
        @(negedge clk);
        core_cmd_taken = 1'b0; core_h2c_rd = 1'b0; core_c2h_wr = 1'b0;
        case (which)
            0: m_pend = 1'b0;
            1: m_h2c_full = 1'b0;
            default: begin m_c2h = d; m_c2h_full = 1'b1; end
        endcase
        check_core();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        void'($urandom(32'd20240611));
        m_ctrl = 8'h00; m_vec = 5'h17; m_pend = 1'b0;
        m_h2c = 8'h00; m_h2c_full = 1'b0; m_c2h = 8'h00; m_c2h_full = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 vaddr", core_cmd_vaddr, 16'h002E);
        chk("R1 req", host_req, 1'b0);
        check_core();
        do_read("R1 ctrl read", 3'd0);
        do_read("R1 cmd read", 3'd1);

        // R11 unmapped addresses
        for (int a = 2; a < 8; a++) begin
            if (a == 4) continue;
            do_write(3'(a), 8'hFF);
            do_read("R11 unmapped read", 3'(a));
        end
        do_read("R11 ctrl unchanged", 3'd0);

        // R3 field layout, reserved bit 2 written as 1
        do_write(3'd0, 8'h7F);
        do_read("R3 ctrl read", 3'd0);
        chk("R3 flags=11", core_host_flags, 2'b11);
        chk("R3 mode=11", core_dma_mode, 2'b11);

        // R9 both enables off keeps request low with a full c2h byte
        do_write(3'd0, 8'h00);
        core_pulse(2, 8'hA5);
        chk("R9 req off", host_req, 1'b0);
        do_write(3'd0, 8'h01);
        chk("R9 rx req", host_req, 1'b1);
        do_write(3'd0, 8'h02);
        chk("R9 tx req empty", host_req, 1'b1);

        // R10 data path
        do_write(3'd4, 8'h3C);
        chk("R10 h2c data", core_h2c_data, 8'h3C);
        chk("R9 tx req full", host_req, 1'b0);
        core_pulse(1, 8'h00);
        do_read("R10 c2h read", 3'd4);
        chk("R10 c2h drained", core_c2h_full, 1'b0);

        // R4 initialise empties both bytes and self-clears
        do_write(3'd4, 8'h11);
        core_pulse(2, 8'h22);
        do_write(3'd0, 8'h83);
        chk("R4 h2c empty", core_h2c_full, 1'b0);
        chk("R4 c2h empty", core_c2h_full, 1'b0);
        do_read("R4 init reads 0", 3'd0);

        // R7 command pending, write of 0 cannot clear it
        do_write(3'd1, 8'h85);
        chk("R7 pending set", core_cmd_pending, 1'b1);
        chk("R6 vaddr 0x0A", core_cmd_vaddr, 16'h000A);
        do_write(3'd1, 8'h00);
        chk("R7 still pending", core_cmd_pending, 1'b1);
        // R8 vector frozen while pending
        do_write(3'd1, 8'h9F);
        do_read("R8 vector frozen", 3'd1);
        chk("R8 vaddr frozen", core_cmd_vaddr, 16'h000A);
        core_pulse(0, 8'h00);
        do_read("R7 cleared by taken", 3'd1);

        // R2 strobe without ack has no effect
        @(negedge clk);
        host_strb = 1'b1; host_ack = 1'b0; host_rd = 1'b0;
        host_addr = 3'd0; host_wdata = 8'hFF;
        @(negedge clk);
        host_strb = 1'b0;
        @(negedge clk);
        check_core();
        do_read("R2 no ack no write", 3'd0);

        // R2 held strobe fires once: taken mid-hold must not re-arm
        @(negedge clk);
        host_strb = 1'b1; host_ack = 1'b1; host_rd = 1'b0;
        host_addr = 3'd1; host_wdata = 8'h86;
        @(negedge clk);
        core_cmd_taken = 1'b1;
        @(negedge clk);
        core_cmd_taken = 1'b0;
        @(negedge clk);
        host_strb = 1'b0; host_ack = 1'b0;
        @(negedge clk);
        m_vec = 5'h06; m_pend = 1'b0;
        chk("R2 single fire", core_cmd_pending, 1'b0);
        check_core();

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] d;
            op = int'($urandom % 9);
            d  = 8'($urandom);
            case (op)
                0: do_write(3'd0, (($urandom % 8) == 0) ? d : (d & 8'h7F));
                1: do_write(3'd1, d);
                2: do_write(3'd4, d);
                3: do_read("R3 random ctrl read", 3'd0);
                4: do_read("R5 random cmd read", 3'd1);
                5: do_read("R10 random data read", 3'd4);
                6: core_pulse(0, d);
                7: core_pulse(1, d);
                default: core_pulse(2, d);
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule